// File: doc/BRIEF.md
# T1 Receive AIS and Loss-of-Signal Alarm Detector

This block watches the recovered receive bit stream of a T1 line and keeps two alarm flags up to date. A qualifying strobe marks each cycle that carries a valid received bit. Cycles without the strobe are ignored. The first flag reports an alarm indication signal, which is an unframed all-ones stream. It is judged once per fixed observation window of 3 ms, which is 4632 bit periods at 1.544 Mbit/s. The window count is the only thing that moves the flag. This makes it robust to a 1e-3 error rate, and the framing pattern of a framed all-ones signal keeps it from asserting.

The second flag reports loss of signal. A long run of consecutive zeros sets it. It clears only once enough ones arrive within a bounded span, and that span opens at the first one seen after the alarm was set. A one-cycle pulse marks each rising and falling edge of either flag, so an interrupt or logging stage can pick up each change without comparing levels.

Top module: `t1_alarm_detector`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) clears both alarm flags and all four change pulses. After reset, the first observation window starts with the first valid bit.
- R2: AIS is set at the last bit of a 4632-valid-bit window that holds 5 or fewer zeros. The flag shows the new value in the cycle after that bit's clock edge.
- R3: AIS is cleared at the last bit of a window that holds 6 or more zeros. Windows are back to back, never overlap, and are counted from reset.
- R4: The AIS flag changes only at a window's last bit. It holds its value at every other bit.
- R5: LOS is set on the 192nd consecutive valid zero. Any valid one restarts the zero run, so 191 zeros followed by a one does not set the alarm.
- R6: While LOS is active, it clears on the 14th one of a span. The span opens at the first one received after the alarm was set, and its length counts that one as bit 1. The span must reach 14 ones within its 112 bits.
- R7: If a span reaches its 112th bit with fewer than 14 ones, LOS stays set. No new span opens until the next one arrives, and zeros before that one are not counted.
- R8: `ais_rise`, `ais_fall`, `los_rise` and `los_fall` are each high for exactly one cycle. That cycle is the one in which the matching flag first shows its new value. At most one pulse per flag is high in any cycle.
- R9: A cycle with `rx_bit_vld` low advances no counter and changes neither flag, whatever `rx_bit` carries.
- R10: The AIS and LOS decisions are independent. When a window's last bit is also the 192nd consecutive zero, both flags change, and both pulses fire, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit_vld | input | 1 | High in cycles that carry a received bit |
| rx_bit | input | 1 | Received data bit |
| ais_alarm | output | 1 | All-ones alarm flag |
| los_alarm | output | 1 | Loss-of-signal alarm flag |
| ais_rise | output | 1 | One-cycle pulse when the AIS flag sets |
| ais_fall | output | 1 | One-cycle pulse when the AIS flag clears |
| los_rise | output | 1 | One-cycle pulse when the LOS flag sets |
| los_fall | output | 1 | One-cycle pulse when the LOS flag clears |

## Verification
The AIS window decision and the LOS zero-run decision can land on the same received bit. That bit is the interesting one, because both flags and two pulses then change in the same cycle. The bench provokes this by sending an all-ones window, which raises AIS. It then sends a window that is all ones except for a final 192 zeros, so that the last bit of the window is also the 192nd zero. The scoreboard expects AIS falling and LOS rising in one output cycle, and any split, a lost pulse or a one-cycle skew is reported as a miscompare.

// File: rtl/t1_alarm_pkg.sv
package t1_alarm_pkg;

    // Default line figures for a 1.544 Mbit/s receive stream
    localparam int unsigned T1_WIN_BITS   = 4632; // 3 ms observation window
    localparam int unsigned T1_AIS_MAXZ   = 5;    // zeros tolerated for AIS
    localparam int unsigned T1_LOS_ZRUN   = 192;  // zero run that raises LOS
    localparam int unsigned T1_LOS_SPAN   = 112;  // span length for LOS recovery
    localparam int unsigned T1_LOS_ONES   = 14;   // ones needed inside a span

    // Index of each alarm inside the flag array of the top level
    localparam int unsigned FLAG_AIS = 0;
    localparam int unsigned FLAG_LOS = 1;
    localparam int unsigned FLAG_CNT = 2;

    // Request toward a hysteretic flag register
    typedef struct packed {
        logic set_req;
        logic clr_req;
    } flag_req_t;

    // Registered state of one alarm flag
    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } flag_stat_t;

    // Width needed to hold values 0..n
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/t1_alarm_flag.sv
module t1_alarm_flag
    import t1_alarm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  flag_req_t  req,
    output flag_stat_t stat
);

    // Set wins over clear if both ever arrive together
    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
        end else begin
            stat.rise <= req.set_req & ~stat.level;
            stat.fall <= req.clr_req & ~req.set_req & stat.level;
            if (req.set_req) begin
                stat.level <= 1'b1;
            end else if (req.clr_req) begin
                stat.level <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/t1_ais_window.sv
module t1_ais_window
    import t1_alarm_pkg::*;
#(
    parameter int unsigned WIN_BITS  = T1_WIN_BITS,
    parameter int unsigned MAX_ZEROS = T1_AIS_MAXZ
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      bit_vld,
    input  logic      bit_d,
    output flag_req_t req,
    output logic      win_end
);

    localparam int unsigned PW = cnt_width(WIN_BITS - 1);
    localparam int unsigned ZW = cnt_width(MAX_ZEROS + 1);
    localparam logic [PW-1:0] LAST_POS = PW'(WIN_BITS - 1);
    localparam logic [ZW-1:0] ZSAT     = ZW'(MAX_ZEROS + 1);
    localparam logic [ZW-1:0] ZLIM     = ZW'(MAX_ZEROS);

    logic [PW-1:0] pos_q;
    logic [ZW-1:0] zeros_q;
    logic [ZW-1:0] zeros_nx;

    // Zero tally including the bit on the input now, saturating one past the limit
    always_comb begin
        if (zeros_q == ZSAT) begin
            zeros_nx = zeros_q;
        end else begin
            zeros_nx = zeros_q + {{(ZW-1){1'b0}}, ~bit_d};
        end
    end

    assign win_end     = bit_vld && (pos_q == LAST_POS);
    assign req.set_req = win_end && (zeros_nx <= ZLIM);
    assign req.clr_req = win_end && (zeros_nx >  ZLIM);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q   <= '0;
            zeros_q <= '0;
        end else if (bit_vld) begin
            if (win_end) begin
                pos_q   <= '0;
                zeros_q <= '0;
            end else begin
                pos_q   <= pos_q + 1'b1;
                zeros_q <= zeros_nx;
            end
        end
    end

endmodule

// File: rtl/t1_los_tracker.sv
module t1_los_tracker
    import t1_alarm_pkg::*;
#(
    parameter int unsigned SET_ZEROS = T1_LOS_ZRUN,
    parameter int unsigned SPAN_BITS = T1_LOS_SPAN,
    parameter int unsigned MIN_ONES  = T1_LOS_ONES
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      bit_vld,
    input  logic      bit_d,
    input  logic      los_active,
    output flag_req_t req
);

    localparam int unsigned RW = cnt_width(SET_ZEROS);
    localparam int unsigned SW = cnt_width(SPAN_BITS);
    localparam int unsigned OW = cnt_width(MIN_ONES);
    localparam logic [RW-1:0] RUN_MAX  = RW'(SET_ZEROS);
    localparam logic [RW-1:0] RUN_TRIP = RW'(SET_ZEROS - 1);
    localparam logic [SW-1:0] SPAN_TOP = SW'(SPAN_BITS - 1);
    localparam logic [OW-1:0] ONES_TOP = OW'(MIN_ONES - 1);

    typedef enum logic [1:0] {
        TRK_RUN,   // no alarm: counting consecutive zeros
        TRK_WAIT,  // alarm set: waiting for a one to open a span
        TRK_SPAN   // alarm set: counting ones inside a span
    } trk_state_e;

    trk_state_e    st_q;
    logic [RW-1:0] zrun_q;
    logic [SW-1:0] len_q;
    logic [OW-1:0] ones_q;

    logic trip, open_span, hit, span_done;

    assign trip      = bit_vld && !los_active && !bit_d && (zrun_q == RUN_TRIP);
    assign open_span = bit_vld && los_active && (st_q != TRK_SPAN) && bit_d;
    assign hit       = bit_vld && los_active && (st_q == TRK_SPAN) && bit_d
                       && (ones_q == ONES_TOP);
    assign span_done = bit_vld && (st_q == TRK_SPAN) && (len_q == SPAN_TOP);

    generate
        if (MIN_ONES == 1) begin : g_single_one
            assign req.clr_req = open_span;
        end else begin : g_many_ones
            assign req.clr_req = hit;
        end
    endgenerate
    assign req.set_req = trip;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= TRK_RUN;
            zrun_q <= '0;
            len_q  <= '0;
            ones_q <= '0;
        end else if (bit_vld) begin
            if (!los_active) begin
                st_q   <= trip ? TRK_WAIT : TRK_RUN;
                len_q  <= '0;
                ones_q <= '0;
                if (bit_d || trip) begin
                    zrun_q <= '0;
                end else if (zrun_q != RUN_MAX) begin
                    zrun_q <= zrun_q + 1'b1;
                end
            end else begin
                zrun_q <= '0;
                if (req.clr_req) begin
                    st_q   <= TRK_RUN;
                    len_q  <= '0;
                    ones_q <= '0;
                end else if (st_q != TRK_SPAN) begin
                    if (bit_d) begin
                        st_q   <= TRK_SPAN;
                        len_q  <= SW'(1);
                        ones_q <= OW'(1);
                    end
                end else if (span_done) begin
                    st_q   <= TRK_WAIT;
                    len_q  <= '0;
                    ones_q <= '0;
                end else begin
                    len_q  <= len_q + 1'b1;
                    ones_q <= ones_q + {{(OW-1){1'b0}}, bit_d};
                end
            end
        end
    end

endmodule

// File: rtl/t1_alarm_detector.sv
module t1_alarm_detector
    import t1_alarm_pkg::*;
#(
    parameter int unsigned WIN_BITS  = T1_WIN_BITS,
    parameter int unsigned AIS_MAXZ  = T1_AIS_MAXZ,
    parameter int unsigned LOS_ZRUN  = T1_LOS_ZRUN,
    parameter int unsigned LOS_SPAN  = T1_LOS_SPAN,
    parameter int unsigned LOS_ONES  = T1_LOS_ONES
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_bit_vld,
    input  logic rx_bit,
    output logic ais_alarm,
    output logic los_alarm,
    output logic ais_rise,
    output logic ais_fall,
    output logic los_rise,
    output logic los_fall
);

    flag_req_t  req_v  [FLAG_CNT];
    flag_stat_t stat_v [FLAG_CNT];
    logic       ais_win_end;

    t1_ais_window #(
        .WIN_BITS  (WIN_BITS),
        .MAX_ZEROS (AIS_MAXZ)
    ) u_ais (
        .clk     (clk),
        .rst     (rst),
        .bit_vld (rx_bit_vld),
        .bit_d   (rx_bit),
        .req     (req_v[FLAG_AIS]),
        .win_end (ais_win_end)
    );

    t1_los_tracker #(
        .SET_ZEROS (LOS_ZRUN),
        .SPAN_BITS (LOS_SPAN),
        .MIN_ONES  (LOS_ONES)
    ) u_los (
        .clk        (clk),
        .rst        (rst),
        .bit_vld    (rx_bit_vld),
        .bit_d      (rx_bit),
        .los_active (stat_v[FLAG_LOS].level),
        .req        (req_v[FLAG_LOS])
    );

    for (genvar g = 0; g < FLAG_CNT; g++) begin : g_flag
        t1_alarm_flag u_flag (
            .clk  (clk),
            .rst  (rst),
            .req  (req_v[g]),
            .stat (stat_v[g])
        );
    end

    assign ais_alarm = stat_v[FLAG_AIS].level;
    assign ais_rise  = stat_v[FLAG_AIS].rise;
    assign ais_fall  = stat_v[FLAG_AIS].fall;
    assign los_alarm = stat_v[FLAG_LOS].level;
    assign los_rise  = stat_v[FLAG_LOS].rise;
    assign los_fall  = stat_v[FLAG_LOS].fall;

endmodule

// File: rtl/t1_alarm_detector_chk.sv
module t1_alarm_detector_chk (
    input logic clk,
    input logic rst,
    input logic rx_bit_vld,
    input logic rx_bit,
    input logic ais_alarm,
    input logic los_alarm,
    input logic ais_rise,
    input logic ais_fall,
    input logic los_rise,
    input logic los_fall,
    input logic ais_win_end
);

    // R4: AIS holds between window boundaries
    p_ais_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !ais_win_end |=> $stable(ais_alarm));

    // R9: an idle cycle moves neither flag
    p_idle_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        !rx_bit_vld |=> ($stable(ais_alarm) && $stable(los_alarm)));

    // R5: LOS only rises right after a valid zero
    p_los_set_zero_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(los_alarm) |-> ($past(rx_bit_vld) && !$past(rx_bit)));

    // R6: LOS only falls right after a valid one
    p_los_clr_one_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(los_alarm) |-> ($past(rx_bit_vld) && $past(rx_bit)));

    // R8: pulses last one cycle and track the flag edges
    p_ais_rise_edge_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(ais_alarm) |-> ais_rise);
    p_ais_fall_edge_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(ais_alarm) |-> ais_fall);
    p_los_rise_edge_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(los_alarm) |-> los_rise);
    p_los_fall_edge_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(los_alarm) |-> los_fall);
    p_pulse_single_r8: assert property (@(posedge clk) disable iff (rst)
        (ais_rise || ais_fall || los_rise || los_fall) |=>
            !($past(ais_rise) && ais_rise) && !($past(los_rise) && los_rise));
    p_pulse_excl_r8: assert property (@(posedge clk) disable iff (rst)
        $countones({ais_rise, ais_fall}) <= 1 && $countones({los_rise, los_fall}) <= 1);

endmodule

bind t1_alarm_detector t1_alarm_detector_chk u_chk (.*);

// File: tb/t1_alarm_detector_tb_top.sv
`timescale 1ns/1ps
module t1_alarm_detector_tb_top;

    localparam int WIN  = 4632;
    localparam int MAXZ = 5;
    localparam int ZRUN = 192;
    localparam int SPAN = 112;
    localparam int ONES = 14;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_bit_vld = 1'b0;
    logic rx_bit = 1'b0;
    logic ais_alarm, los_alarm, ais_rise, ais_fall, los_rise, los_fall;

    always #2 clk = ~clk;  // 250 MHz

    t1_alarm_detector dut_i (
        .clk        (clk),
        .rst        (rst),
        .rx_bit_vld (rx_bit_vld),
        .rx_bit     (rx_bit),
        .ais_alarm  (ais_alarm),
        .los_alarm  (los_alarm),
        .ais_rise   (ais_rise),
        .ais_fall   (ais_fall),
        .los_rise   (los_rise),
        .los_fall   (los_fall)
    );

    // Expected output word: {ais, los, ais_rise, ais_fall, los_rise, los_fall}
    logic [5:0] exp_q [$];
    string      tag_q [$];
    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    // Reference state, kept from the requirements
    int  m_bits = 0;      // valid bits since reset
    int  m_wz = 0;        // zeros in current window (unsaturated)
    int  m_run = 0;       // consecutive zeros
    int  m_len = 0;       // 0 = no span open
    int  m_ones = 0;
    bit  m_ais = 0, m_los = 0;
    int  gap_ctr = 0;
    bit  gaps_on = 0;

    task automatic send(input bit b, input bit en, input string tag);
        bit old_ais, old_los;
        old_ais = m_ais;
        old_los = m_los;
        @(negedge clk);
        rx_bit_vld = en;
        rx_bit = b;
        if (en) begin
            m_bits++;
            if (!b) m_wz++;
            if (m_bits % WIN == 0) begin
                m_ais = (m_wz <= MAXZ);
                m_wz = 0;
            end
            if (!old_los) begin
                m_run = b ? 0 : m_run + 1;
                if (m_run >= ZRUN) begin
                    m_los = 1;
                    m_run = 0;
                    m_len = 0;
                    m_ones = 0;
                end
            end else if (m_len == 0) begin
                if (b) begin
                    m_len = 1;
                    m_ones = 1;
                end
            end else begin
                m_len++;
                if (b) m_ones++;
                if (m_ones >= ONES) begin
                    m_los = 0;
                    m_len = 0;
                    m_ones = 0;
                end else if (m_len >= SPAN) begin
                    m_len = 0;
                    m_ones = 0;
                end
            end
        end
        exp_q.push_back({m_ais, m_los, m_ais & ~old_ais, old_ais & ~m_ais,
                         m_los & ~old_los, old_los & ~m_los});
        tag_q.push_back(tag);
    endtask

    // Valid bit, with an idle cycle (data 0) inserted now and then when enabled
    task automatic bitv(input bit b, input string tag);
        if (gaps_on) begin
            gap_ctr++;
            if (gap_ctr % 7 == 0) send(1'b0, 1'b0, "R9");
        end
        send(b, 1'b1, tag);
    endtask

    task automatic run_bits(input bit b, input int n, input string tag);
        for (int i = 0; i < n; i++) bitv(b, tag);
    endtask

    // Ones up to the last bit before the next window edge minus 'keep'
    task automatic pad_to(input int keep, input string tag);
        int target;
        target = ((m_bits / WIN) + 1) * WIN - keep;
        while (m_bits < target) bitv(1'b1, tag);
    endtask

    // Monitor: compares each output cycle against the scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [5:0] e, a;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = {ais_alarm, los_alarm, ais_rise, ais_fall, los_rise, los_fall};
                vectors++;
                if (a !== e) begin
                    miscompares++;
                    $display("FAIL %s at bit %0d: actual %b expected %b", t, m_bits, a, e);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: run hung, actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        // R1: reset state
        vectors++;
        if ({ais_alarm, los_alarm, ais_rise, ais_fall, los_rise, los_fall} !== 6'b0) begin
            miscompares++;
            $display("FAIL R1 reset: actual %b expected %b",
                     {ais_alarm, los_alarm, ais_rise, ais_fall, los_rise, los_fall}, 6'b0);
        end
        @(negedge clk);
        rst = 1'b0;

        // R5: 191 zeros then a one does not trip; a later full run of 192 does
        run_bits(1'b0, ZRUN - 1, "R5");
        bitv(1'b1, "R5");
        run_bits(1'b0, ZRUN + 40, "R5");
        // R9: idle cycles carrying ones must not open a span
        for (int i = 0; i < 20; i++) send(1'b1, 1'b0, "R9");
        // R7: a span with a single one expires, then zeros are not counted
        bitv(1'b1, "R7");
        run_bits(1'b0, SPAN - 1, "R7");
        run_bits(1'b0, 30, "R7");
        // R7: 13 ones spread across a full span, still no recovery
        for (int k = 0; k < SPAN; k++) bitv((k % 8 == 0 && k < 104) ? 1'b1 : 1'b0, "R7");
        run_bits(1'b0, 10, "R7");
        // R6: 14th one of a fresh span clears, here with gaps in the stream
        gaps_on = 1;
        for (int k = 0; k < 13; k++) begin
            bitv(1'b1, "R6");
            run_bits(1'b0, 6, "R6");
        end
        bitv(1'b1, "R6");
        run_bits(1'b1, 20, "R6");
        // R3: first window carried many zeros, AIS remains clear
        pad_to(0, "R3");
        // R2: window with exactly 5 zeros sets AIS
        run_bits(1'b0, MAXZ, "R2");
        pad_to(0, "R2");
        // R4: window with 5 zeros at its end keeps AIS set
        pad_to(MAXZ, "R4");
        run_bits(1'b0, MAXZ, "R4");
        // R3: window with 6 zeros clears AIS
        run_bits(1'b0, MAXZ + 1, "R3");
        pad_to(0, "R3");
        // R2: all-ones window sets AIS again
        gaps_on = 0;
        pad_to(0, "R2");
        // R10: the window's last bit is also the 192nd zero
        pad_to(ZRUN, "R10");
        run_bits(1'b0, ZRUN, "R10");
        // R8: recovery pulses after the simultaneous change
        run_bits(1'b1, ONES + 10, "R8");
        run_bits(1'b1, 50, "R8");

        while (exp_q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule